// File: doc/BRIEF.md
# Receive Sample Error Concealment Stage

This stage sits after a digital audio receiver. It takes one stereo sample pair per frame and cleans it up before the rest of the chip sees it. If the receiver flags the frame as damaged, a selectable policy decides what leaves the stage:

- the last clean sample of each channel,
- silence, or
- the damaged data as received.

Separately, the stage can shorten the word length of PCM audio. The receiver supplies a 4-bit length code taken from channel status, and the stage clears the least significant bits that the code marks as unused.

Frames move on a valid/ready stream on both sides, with a single output register between them. A frame is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or when the consumer takes its content in the same cycle. Once `out_valid` is raised, it stays high and the output data stays unchanged until `out_ready` is seen. Two things are taken from the inputs on the accepting edge:

- the control inputs: raw mode, non-audio, length code;
- the configuration inputs: policy and truncation enable.

Changes to them while a frame is waiting therefore have no effect on that frame.

Top module: `rx_conceal`

## Requirements
- R1: `in_ready` equals (not `out_valid`) or `out_ready`. An accepted frame appears with `out_valid` high on the next cycle. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_left` and `out_right` hold their values.
- R2: A frame counts as errored when any one of `in_err_parity`, `in_err_biphase` or `in_err_conf` is high at acceptance.
- R3: With policy code 00 on an errored frame, each channel outputs the most recent error-free received sample of that channel. After reset that stored sample is zero. Only error-free accepted frames update it.
- R4: With policy code 01 on an errored frame, both channels output zero.
- R5: With policy code 10 or 11 on an errored frame, both channels output the received samples unchanged.
- R6: When `in_raw` is high, both channels output the received samples unchanged. The error policy and truncation are both ignored.
- R7: When truncation is enabled, concealment is applied first. The effective length is 24 minus the length code, or 8 if that result is below 1. The bits below the top effective-length bits are cleared; with the defaults this means the low `code` bits become zero.
- R8: When `in_nonaudio` is high, no truncation is applied, even with truncation enabled.
- R9: With truncation disabled, all 24 bits of the (concealed) sample are output.
- R10: The policy, truncation enable, length code and mode flags that apply to a frame are the values present at its acceptance edge.
- R11: During reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input frame valid |
| in_ready | output | 1 | Stage can accept a frame |
| in_left | input | 24 | Received left sample |
| in_right | input | 24 | Received right sample |
| in_err_parity | input | 1 | Parity error for this frame |
| in_err_biphase | input | 1 | Line-code (bi-phase) error for this frame |
| in_err_conf | input | 1 | Confidence error for this frame |
| in_raw | input | 1 | Raw pass-through mode |
| in_nonaudio | input | 1 | Stream flagged as non-PCM |
| in_len_code | input | 4 | Channel-status word length code |
| cfg_policy | input | 2 | Error policy: 00 hold, 01 zero, 10/11 pass |
| cfg_trunc_en | input | 1 | Enable word-length truncation |
| out_valid | output | 1 | Output frame valid |
| out_ready | input | 1 | Consumer takes output frame |
| out_left | output | 24 | Processed left sample |
| out_right | output | 24 | Processed right sample |

## Verification
`in_ready` responds in the same cycle to `out_valid` and `out_ready`. An accepted frame appears on `out_valid`, `out_left` and `out_right` exactly one clock edge after acceptance, and it stays there for as long as `out_ready` is low. The bench changes inputs only on falling edges and keeps a reference state that it advances once per cycle. At each falling edge it compares the outputs with the model's state after the previous rising edge, before it drives the next inputs. Each expected frame is computed when it is accepted, using the configuration and the stored clean samples as they are at that edge.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  typedef enum logic [1:0] {
    POL_HOLD = 2'b00,
    POL_ZERO = 2'b01,
    POL_PASS = 2'b10,
    POL_RSVD = 2'b11
  } policy_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/rxc_conceal_ch.sv
module rxc_conceal_ch
  import rxc_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic         err,
  input  logic         raw,
  input  policy_e      policy,
  input  logic [W-1:0] sample_i,
  output logic [W-1:0] conc_o
);
  logic [W-1:0] hold_q;

  // Last clean sample of this channel; zero after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_q <= '0;
    else if (accept && !err) hold_q <= sample_i;
  end

  always_comb begin
    conc_o = sample_i;
    if (!raw && err) begin
      unique case (policy)
        POL_HOLD: conc_o = hold_q;
        POL_ZERO: conc_o = '0;
        default:  conc_o = sample_i;
      endcase
    end
  end

  assert_hold_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !err) |=> hold_q == $past(sample_i));

  assert_hold_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && err) |=> $stable(hold_q));
endmodule

// File: rtl/rxc_trunc.sv
module rxc_trunc #(
  parameter int W       = 24,
  parameter int CW      = 4,
  parameter int MIN_LEN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] code,
  output logic [W-1:0]  mask_o
);
  localparam int LW = $clog2(W + 1);

  logic [LW-1:0] eff_len;
  int            raw_len;
  int            drop;

  always_comb begin
    raw_len = W - int'(code);
    if (raw_len < 1) eff_len = LW'(MIN_LEN);
    else             eff_len = LW'(raw_len);
    drop = W - int'(eff_len);
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign mask_o[i] = !en || (i >= drop);
  end

  assert_mask_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $countones(mask_o) == int'(eff_len));

  assert_mask_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> &mask_o);
endmodule

// File: rtl/rx_conceal.sv
module rx_conceal
  import rxc_pkg::*;
#(
  parameter int W       = 24,
  parameter int CW      = 4,
  parameter int MIN_LEN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_left,
  input  logic [W-1:0]  in_right,
  input  logic          in_err_parity,
  input  logic          in_err_biphase,
  input  logic          in_err_conf,
  input  logic          in_raw,
  input  logic          in_nonaudio,
  input  logic [CW-1:0] in_len_code,
  input  logic [1:0]    cfg_policy,
  input  logic          cfg_trunc_en,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_left,
  output logic [W-1:0]  out_right
);
  logic         accept;
  logic         frame_err;
  logic         trunc_on;
  logic [W-1:0] mask;
  logic [W-1:0] samp [NUM_CH];
  logic [W-1:0] conc [NUM_CH];

  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign frame_err = in_err_parity | in_err_biphase | in_err_conf;
  assign trunc_on  = cfg_trunc_en && !in_nonaudio && !in_raw;
  assign samp[0]   = in_left;
  assign samp[1]   = in_right;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    rxc_conceal_ch #(.W(W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .err      (frame_err),
      .raw      (in_raw),
      .policy   (policy_e'(cfg_policy)),
      .sample_i (samp[c]),
      .conc_o   (conc[c])
    );
  end

  rxc_trunc #(.W(W), .CW(CW), .MIN_LEN(MIN_LEN)) u_trunc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (trunc_on),
    .code   (in_len_code),
    .mask_o (mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_left  <= conc[0] & mask;
      out_right <= conc[1] & mask;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_stall_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_left) && $stable(out_right));

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_zero_policy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && frame_err && !in_raw && cfg_policy == 2'b01) |=> (out_left == '0 && out_right == '0));

  assert_raw_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_raw) |=> (out_left == $past(in_left) && out_right == $past(in_right)));

  assert_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_trunc_en && !in_nonaudio && !in_raw && int'(in_len_code) < W)
      |=> ((out_left & ~({W{1'b1}} << $past(in_len_code))) == '0));

  assert_nonaudio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_nonaudio && !frame_err) |=> (out_left == $past(in_left)));
endmodule

// File: tb/rx_conceal_tb.sv
`timescale 1ns/1ps
module rx_conceal_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_left = '0;
  logic [23:0] in_right = '0;
  logic        in_err_parity = 1'b0;
  logic        in_err_biphase = 1'b0;
  logic        in_err_conf = 1'b0;
  logic        in_raw = 1'b0;
  logic        in_nonaudio = 1'b0;
  logic [3:0]  in_len_code = '0;
  logic [1:0]  cfg_policy = 2'b00;
  logic        cfg_trunc_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_left;
  logic [23:0] out_right;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic        m_valid = 1'b0;
  logic [23:0] m_l = '0, m_r = '0;
  logic [23:0] h_l = '0, h_r = '0;
  string       m_tag = "R1";

  always #2.5 clk = ~clk;

  rx_conceal u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right),
    .in_err_parity(in_err_parity), .in_err_biphase(in_err_biphase), .in_err_conf(in_err_conf),
    .in_raw(in_raw), .in_nonaudio(in_nonaudio), .in_len_code(in_len_code),
    .cfg_policy(cfg_policy), .cfg_trunc_en(cfg_trunc_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left), .out_right(out_right)
  );

  task automatic check(input string tag, input string what, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] model(input logic [23:0] x, input logic [23:0] hold,
      input logic e, input logic rw, input logic na, input logic [3:0] code,
      input logic [1:0] pol, input logic tr);
    logic [23:0] v;
    int len;
    if (rw) return x;
    v = x;
    if (e) begin
      if (pol == 2'b00)      v = hold;
      else if (pol == 2'b01) v = '0;
    end
    if (tr && !na) begin
      len = 24 - int'(code);
      if (len < 1) len = 8;
      for (int i = 0; i < 24 - len; i++) v[i] = 1'b0;
    end
    return v;
  endfunction

  task automatic cyc(input logic v, input logic [23:0] l, input logic [23:0] r,
      input logic p, input logic b, input logic c, input logic rw, input logic na,
      input logic [3:0] code, input logic [1:0] pol, input logic tr, input logic rdy,
      input string tag);
    logic acc, e;
    @(negedge clk);
    check("R1", "out_valid", {23'd0, out_valid}, {23'd0, m_valid});
    check("R1", "in_ready", {23'd0, in_ready}, {23'd0, (!m_valid || out_ready)});
    if (m_valid) begin
      check(m_tag, "out_left", out_left, m_l);
      check(m_tag, "out_right", out_right, m_r);
    end
    in_valid = v; in_left = l; in_right = r;
    in_err_parity = p; in_err_biphase = b; in_err_conf = c;
    in_raw = rw; in_nonaudio = na; in_len_code = code;
    cfg_policy = pol; cfg_trunc_en = tr; out_ready = rdy;
    acc = v && (!m_valid || rdy);
    e = p | b | c;
    if (acc) begin
      m_l = model(l, h_l, e, rw, na, code, pol, tr);
      m_r = model(r, h_r, e, rw, na, code, pol, tr);
      if (!e) begin h_l = l; h_r = r; end
      m_valid = 1'b1;
      m_tag = tag;
    end else if (rdy) begin
      m_valid = 1'b0;
    end
  endtask

  task automatic fr(input logic [23:0] l, input logic [23:0] r, input logic p, input logic b,
      input logic c, input logic rw, input logic na, input logic [3:0] code,
      input logic [1:0] pol, input logic tr, input string tag);
    cyc(1'b1, l, r, p, b, c, rw, na, code, pol, tr, 1'b1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "out_valid in reset", {23'd0, out_valid}, 24'd0);
    check("R11", "in_ready in reset", {23'd0, in_ready}, 24'd1);
    rst_n = 1'b1;
    // errored frame before any clean one: hold gives zero (R3)
    fr(24'h123456, 24'h654321, 1, 0, 0, 0, 0, 4'd0, 2'b00, 0, "R3");
    // clean frames, no truncation (R9)
    fr(24'hABCDEF, 24'h0F0F0F, 0, 0, 0, 0, 0, 4'd4, 2'b00, 0, "R9");
    fr(24'h800001, 24'h7FFFFF, 0, 0, 0, 0, 0, 4'd0, 2'b01, 0, "R9");
    // each error flag alone with zero policy (R2, R4)
    fr(24'h111111, 24'h222222, 1, 0, 0, 0, 0, 4'd0, 2'b01, 0, "R2");
    fr(24'h333333, 24'h444444, 0, 1, 0, 0, 0, 4'd0, 2'b01, 0, "R2");
    fr(24'h555555, 24'h666666, 0, 0, 1, 0, 0, 4'd0, 2'b01, 0, "R4");
    // hold repeats last clean sample (R3)
    fr(24'hFEDCBA, 24'h13579B, 0, 0, 0, 0, 0, 4'd0, 2'b00, 0, "R3");
    fr(24'h000000, 24'hFFFFFF, 0, 1, 0, 0, 0, 4'd0, 2'b00, 0, "R3");
    fr(24'h0A0A0A, 24'h0B0B0B, 1, 1, 1, 0, 0, 4'd0, 2'b00, 0, "R3");
    // pass and reserved codes (R5)
    fr(24'hC0FFEE, 24'hBADA55, 1, 0, 0, 0, 0, 4'd0, 2'b10, 0, "R5");
    fr(24'hDEAD01, 24'hBEEF02, 0, 0, 1, 0, 0, 4'd0, 2'b11, 0, "R5");
    // raw mode ignores policy and truncation (R6)
    fr(24'hFFFFFF, 24'hA5A5A5, 1, 0, 0, 1, 0, 4'd8, 2'b01, 1, "R6");
    fr(24'hFFFFFF, 24'h5A5A5A, 0, 0, 0, 1, 0, 4'd15, 2'b00, 1, "R6");
    // truncation lengths (R7)
    fr(24'hFFFFFF, 24'hFFFFFF, 0, 0, 0, 0, 0, 4'd0, 2'b00, 1, "R7");
    fr(24'hFFFFFF, 24'h123456, 0, 0, 0, 0, 0, 4'd4, 2'b00, 1, "R7");
    fr(24'hFFFFFF, 24'hFFFFFF, 0, 0, 0, 0, 0, 4'd15, 2'b00, 1, "R7");
    // concealment before truncation: held sample then truncated (R7)
    fr(24'h000000, 24'h000000, 1, 0, 0, 0, 0, 4'd8, 2'b00, 1, "R7");
    // non-audio skips truncation (R8)
    fr(24'hFFFFFF, 24'h00FFFF, 0, 0, 0, 0, 1, 4'd8, 2'b00, 1, "R8");
    // back-pressure with config change while waiting (R1, R10)
    cyc(1, 24'h9999AA, 24'h8888BB, 0, 0, 0, 0, 0, 4'd2, 2'b00, 0, 0, "R1");
    cyc(1, 24'h777777, 24'h666666, 1, 0, 0, 0, 0, 4'd3, 2'b00, 1, 0, "R10");
    cyc(1, 24'h777777, 24'h666666, 1, 0, 0, 0, 0, 4'd3, 2'b01, 1, 0, "R10");
    cyc(1, 24'h777777, 24'h666666, 1, 0, 0, 0, 0, 4'd3, 2'b10, 1, 0, "R10");
    cyc(1, 24'h777777, 24'h666666, 1, 0, 0, 0, 0, 4'd3, 2'b10, 1, 1, "R10");
    cyc(0, 24'h0, 24'h0, 0, 0, 0, 0, 0, 4'd0, 2'b00, 0, 0, "R1");
    cyc(0, 24'h0, 24'h0, 0, 0, 0, 0, 0, 4'd0, 2'b00, 0, 0, "R1");
    cyc(1, 24'h424242, 24'h242424, 0, 0, 0, 0, 0, 4'd0, 2'b00, 0, 1, "R1");
    repeat (4) cyc(0, 24'h0, 24'h0, 0, 0, 0, 0, 0, 4'd0, 2'b00, 0, 1, "R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule